// File: doc/BRIEF.md
# I2C Bit-Level Sequencer

This block drives the clock and data wires of an I2C bus for one bit-sized action at a time. A byte controller above it asks for one of five things: a START, a repeated START, a STOP, sending a single bit, or receiving a single bit. Each action is split into five equal phases. A programmable prescaler sets the length of each phase, so one action spans one SCL period. Both wires are driven open-drain: an `*_oe` output at 1 pulls the wire low, and at 0 lets it float high.

The incoming wire levels are passed through a flop synchronizer before any other logic looks at them. A line monitor watches for START and STOP conditions on the bus, whichever master made them, and keeps a busy flag. The sequencer reports arbitration loss if it has released SDA but reads it low at a check point. In that case it drops the action and releases both wires.

Commands use a valid/ready handshake. The byte controller holds `cmd_valid` together with the opcode until `cmd_ready` is seen high on a rising edge. `cmd_ready` stays low from acceptance until the action finishes, is aborted, or the block is disabled. The result side has no back-pressure: `done` or `arb_lost` is a single-cycle pulse that the controller must catch. A repeated START uses the same opcode as START.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: After reset, and in any cycle with `enable` low, both `scl_oe` and `sda_oe` are 0 and `bus_busy` is 0. `cmd_ready` equals `enable` whenever no action is in progress.
- R2: Opcodes are 0 = START, 1 = STOP, 2 = WRITE (bit taken from `cmd_wbit`), 3 = READ. An action is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the next cycle until completion. Completion raises `done` for exactly one cycle.
- R3: With P = {`presc_hi`,`presc_lo`} captured at acceptance, every action takes five phases of P+1 cycles each. When SCL was already high, `done` rises 5(P+1) cycles after the accepting edge. When the action releases SCL after it was low, the synchronizer latency adds its two cycles: 5(P+1)+2.
- R4: START releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. After such a falling SDA edge with SCL high is seen, `bus_busy` is 1 by the time `done` rises.
- R5: STOP pulls SDA low, releases SCL, then releases SDA while SCL is high. A rising SDA edge with SCL high, whether made by this block or by another master, clears `bus_busy`.
- R6: During WRITE the SDA level is set only in the first phase, while SCL is still at its previous level. The SDA level at the rising SCL edge equals `cmd_wbit`.
- R7: READ leaves SDA released. `rx_bit` takes the synchronized SDA level at the end of the third phase, which is the middle of the SCL-high time. `rx_bit` holds that value through later non-read actions.
- R8: Arbitration is checked where SDA should be high: at the end of the third phase of START and of WRITE with bit 1, and at the end of the fifth phase of STOP. If SDA is read low at such a point, the block pulses `arb_lost` for one cycle instead of `done`, releases both wires, and becomes ready again.
- R9: While the block releases SCL but the synchronized SCL is low (for example, a slave stretching the clock), phase timing stops. If SCL is released K cycles after acceptance by an outside holder, a WRITE completes K+2+4(P+1) cycles after acceptance.
- R10: Dropping `enable` during an action releases both wires on the next edge, drops `cmd_ready`, clears `bus_busy`, and produces no `done` for that action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Core enable; low forces idle with both wires released |
| presc_lo | input | PRE_W/2 | Low half of the prescale value |
| presc_hi | input | PRE_W-PRE_W/2 | High half of the prescale value |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | Opcode: 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wbit | input | 1 | Bit to send for WRITE |
| done | output | 1 | One-cycle pulse when an action completes |
| arb_lost | output | 1 | One-cycle pulse when arbitration is lost |
| rx_bit | output | 1 | Last bit sampled by READ |
| bus_busy | output | 1 | A START has been seen and no STOP since |
| scl_i | input | 1 | SCL wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA wire level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench uses the default 16-bit prescale and the two-flop synchronizer. It loads prescale values from 1 to 5 through the two halves, so every action finishes within a few dozen cycles. This makes the exact phase counts, the extra two cycles of synchronizer latency on a rising SCL, and a 15-cycle clock stretch all checkable to the cycle. The bench models the open-drain wires with a second driver that can hold SDA or SCL low. This lets it reach arbitration loss, reads of 0 and 1, a STOP made by another master, and a disable in the middle of an action.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] SAMPLE_PH = 3'd2;
  localparam logic [PH_W-1:0] LAST_PH   = 3'd4;

  // SCL pull for phases 1..4 (phase 0 keeps the previous level)
  function automatic logic scl_pull_at(op_e op, logic [PH_W-1:0] ph);
    return (ph == LAST_PH) && (op != OP_STOP);
  endfunction

  function automatic logic sda_pull_at(op_e op, logic wbit, logic [PH_W-1:0] ph);
    case (op)
      OP_START: return ph >= 3'd3;
      OP_STOP:  return ph <= 3'd2;
      OP_WRITE: return !wbit;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d[g]};
      end
      assign q[g] = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         hold,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == '0) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (hold)        cnt <= cnt;
    else if (cnt == '0)   cnt <= reload_val;
    else                  cnt <= cnt - 1'b1;
  end

  assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(cnt));
endmodule

// File: rtl/i2cb_busmon.sv
module i2cb_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);
  logic sda_d;
  logic start_seen, stop_seen;

  assign start_seen = scl_s && sda_d && !sda_s;
  assign stop_seen  = scl_s && !sda_d && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      sda_d <= sda_s;
      if (!enable)         busy <= 1'b0;
      else if (start_seen) busy <= 1'b1;
      else if (stop_seen)  busy <= 1'b0;
    end
  end

  assert_busy_rise_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scl_s));
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(enable)) |-> $past(sda_s));
endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
  import i2cb_pkg::*;
#(
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [PRE_W/2-1:0]       presc_lo,
  input  logic [PRE_W-PRE_W/2-1:0] presc_hi,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic                     cmd_wbit,
  output logic                     done,
  output logic                     arb_lost,
  output logic                     rx_bit,
  output logic                     bus_busy,
  input  logic                     scl_i,
  output logic                     scl_oe,
  input  logic                     sda_i,
  output logic                     sda_oe
);
  logic [1:0]       sync_q;
  logic             scl_s, sda_s;
  logic             active;
  op_e              op_q;
  op_e              cmd_op_e;
  logic             wbit_q;
  logic [PH_W-1:0]  ph, ph_nx;
  logic [PRE_W-1:0] presc_q;
  logic             accept, hold, tick, at_sample, at_last, arb_hit;

  i2cb_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2cb_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy)
  );

  assign cmd_op_e  = op_e'(cmd_op);
  assign cmd_ready = enable && !active;
  assign accept    = cmd_valid && cmd_ready;
  // released SCL not yet seen high: stall phase timing (stretching)
  assign hold      = active && !scl_oe && !scl_s;

  i2cb_tick #(.W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val({presc_hi, presc_lo}), .reload_val(presc_q),
    .hold(hold), .tick(tick)
  );

  assign ph_nx     = ph + 3'd1;
  assign at_sample = tick && (ph == SAMPLE_PH);
  assign at_last   = tick && (ph == LAST_PH);
  assign arb_hit   = active && !sda_s &&
                     ((at_sample && ((op_q == OP_START) || (op_q == OP_WRITE && wbit_q))) ||
                      (at_last && (op_q == OP_STOP)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      op_q     <= OP_START;
      wbit_q   <= 1'b0;
      ph       <= '0;
      presc_q  <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      done     <= 1'b0;
      arb_lost <= 1'b0;
      rx_bit   <= 1'b0;
    end else if (!enable) begin
      active   <= 1'b0;
      ph       <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      done     <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      done     <= 1'b0;
      arb_lost <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        op_q    <= cmd_op_e;
        wbit_q  <= cmd_wbit;
        presc_q <= {presc_hi, presc_lo};
        ph      <= '0;
        sda_oe  <= sda_pull_at(cmd_op_e, cmd_wbit, 3'd0);
      end else if (active && tick) begin
        if (arb_hit) begin
          active   <= 1'b0;
          ph       <= '0;
          scl_oe   <= 1'b0;
          sda_oe   <= 1'b0;
          arb_lost <= 1'b1;
        end else if (ph == LAST_PH) begin
          active <= 1'b0;
          ph     <= '0;
          done   <= 1'b1;
        end else begin
          ph     <= ph_nx;
          scl_oe <= scl_pull_at(op_q, ph_nx);
          sda_oe <= sda_pull_at(op_q, wbit_q, ph_nx);
          if (op_q == OP_READ && ph == SAMPLE_PH) rx_bit <= sda_s;
        end
      end
    end
  end

  assert_disabled_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe));
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (op_q == OP_WRITE || op_q == OP_READ) && ph != 3'd0) |-> $stable(sda_oe));
  assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!scl_oe && !sda_oe && !done));
  assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold && enable) |=> $stable(ph));
endmodule

// File: tb/test_i2c_bit_sequencer.sv
module test_i2c_bit_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, enable;
  logic [7:0] presc_lo, presc_hi;
  logic cmd_valid, cmd_ready, cmd_wbit;
  logic [1:0] cmd_op;
  logic done, arb_lost, rx_bit, bus_busy;
  logic scl_oe, sda_oe;
  logic slave_scl_low, slave_sda_low;
  logic scl_line, sda_line;
  logic rise_sda;
  int   nchk = 0, nfail = 0, done_seen = 0;

  assign scl_line = ~(scl_oe | slave_scl_low);
  assign sda_line = ~(sda_oe | slave_sda_low);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge scl_line) rise_sda = sda_line;
  always @(posedge clk) if (done) done_seen++;

  i2c_bit_sequencer i_i2c_bit_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .presc_lo(presc_lo), .presc_hi(presc_hi),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .done(done), .arb_lost(arb_lost), .rx_bit(rx_bit), .bus_busy(bus_busy),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        wb;
    logic [15:0] pre;
    logic        slv;
    logic [7:0]  cyc;
    logic        rb;
    logic        busy;
    logic        rise;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b0, 16'd3, 1'b0, 8'd20, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 16'd3, 1'b0, 8'd22, 1'b0, 1'b1, 1'b1},
    '{2'd2, 1'b0, 16'd3, 1'b0, 8'd22, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b0, 16'd3, 1'b1, 8'd22, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b0, 16'd2, 1'b0, 8'd17, 1'b1, 1'b1, 1'b1},
    '{2'd0, 1'b0, 16'd2, 1'b0, 8'd17, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 16'd1, 1'b0, 8'd12, 1'b0, 1'b1, 1'b1},
    '{2'd1, 1'b0, 16'd5, 1'b0, 8'd32, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 16'd5, 1'b0, 8'd30, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b0, 16'd1, 1'b0, 8'd12, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic wb, input logic [15:0] pre,
                        input int k, output int n, output logic gd, output logic ga,
                        output logic rdy_mid);
    @(negedge clk);
    cmd_op = op; cmd_wbit = wb; presc_lo = pre[7:0]; presc_hi = pre[15:8];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    n = 0; gd = 1'b0; ga = 1'b0; rdy_mid = 1'b1;
    while (!gd && !ga && n < 400) begin
      @(posedge clk);
      #1 n++;
      if (n == 1) rdy_mid = cmd_ready;
      gd = done; ga = arb_lost;
      if (k > 0 && n == k) begin
        #(CLK_PERIOD/2 - 1) slave_scl_low = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n; logic gd, ga, rm; int d0;
    rst_n = 1'b0; enable = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wbit = 1'b0;
    presc_lo = 8'd0; presc_hi = 8'd0; slave_scl_low = 1'b0; slave_sda_low = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R1 scl released", scl_oe, 0);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 busy clear", bus_busy, 0);
    chk("R2 no done at reset", done, 0);
    @(negedge clk) enable = 1'b0;
    #1 chk("R1 not ready when disabled", cmd_ready, 0);
    @(negedge clk) enable = 1'b1;

    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk) slave_sda_low = v.slv;
      run_op(v.op, v.wb, v.pre, 0, n, gd, ga, rm);
      chk($sformatf("R3 cycles vec%0d", i), n, int'(v.cyc));
      chk($sformatf("R2 done vec%0d", i), gd, 1);
      chk($sformatf("R2 ready low vec%0d", i), rm, 0);
      chk($sformatf("R8 no arb vec%0d", i), ga, 0);
      if (v.op == 2'd1) chk($sformatf("R5 busy after stop vec%0d", i), bus_busy, int'(v.busy));
      else              chk($sformatf("R4 busy vec%0d", i), bus_busy, int'(v.busy));
      if (v.op == 2'd3) chk($sformatf("R7 rx_bit vec%0d", i), rx_bit, int'(v.rb));
      if (v.op == 2'd2) chk($sformatf("R6 sda at scl rise vec%0d", i), rise_sda, int'(v.rise));
      if (v.op == 2'd3) chk($sformatf("R7 sda at scl rise vec%0d", i), rise_sda, int'(v.rise));
      @(posedge clk);
      #1 chk($sformatf("R2 done single vec%0d", i), done, 0);
      @(negedge clk) slave_sda_low = 1'b0;
    end
    chk("R7 rx_bit held", rx_bit, 1);

    // arbitration loss, then another master's STOP
    run_op(2'd0, 1'b0, 16'd3, 0, n, gd, ga, rm);
    chk("R4 start before arb", n, 20);
    @(negedge clk) slave_sda_low = 1'b1;
    run_op(2'd2, 1'b1, 16'd3, 0, n, gd, ga, rm);
    chk("R8 arb flagged", ga, 1);
    chk("R8 no done", gd, 0);
    chk("R8 arb cycle", n, 14);
    chk("R8 scl released", scl_oe, 0);
    chk("R8 sda released", sda_oe, 0);
    chk("R8 ready again", cmd_ready, 1);
    chk("R5 busy kept", bus_busy, 1);
    repeat (4) @(negedge clk);
    slave_sda_low = 1'b0;
    repeat (5) @(posedge clk);
    #1 chk("R5 foreign stop clears busy", bus_busy, 0);

    // clock stretching
    run_op(2'd0, 1'b0, 16'd3, 0, n, gd, ga, rm);
    chk("R4 start before stretch", n, 20);
    @(negedge clk) slave_scl_low = 1'b1;
    run_op(2'd2, 1'b0, 16'd3, 15, n, gd, ga, rm);
    chk("R9 stretched write cycles", n, 33);
    chk("R9 stretched done", gd, 1);
    run_op(2'd1, 1'b0, 16'd3, 0, n, gd, ga, rm);
    chk("R5 stop cycles", n, 22);
    chk("R5 busy cleared", bus_busy, 0);

    // disable during an action
    run_op(2'd0, 1'b0, 16'd3, 0, n, gd, ga, rm);
    @(negedge clk);
    cmd_op = 2'd2; cmd_wbit = 1'b0; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) enable = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 scl released", scl_oe, 0);
    chk("R10 sda released", sda_oe, 0);
    chk("R10 not ready", cmd_ready, 0);
    chk("R10 busy cleared", bus_busy, 0);
    d0 = done_seen;
    repeat (40) @(posedge clk);
    #1 chk("R10 no done", done_seen, d0);
    @(negedge clk) enable = 1'b1;
    #1 chk("R10 ready after enable", cmd_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule